// File: doc/BRIEF.md
# Stream Table Walker

This block is the front end of an I/O memory management unit. A device request carries a stream identifier and a task index. The walker uses the identifier to find the device's stream table entry in memory. It then returns the translation configuration the rest of the unit needs: the translation mode, the virtual-machine tag, the stage-1 context pointer, the stage-2 table base and, for stage-1 modes, the address and table base of the task's context descriptor.

The layout of the table is chosen by configuration inputs: the table base, a flag that selects a flat array or a split two-level table, and the log2 of the number of stream identifiers the table covers. In the split layout, the top 8 identifier bits pick an 8-byte level-1 descriptor. That descriptor points to an array of 64-byte entries, which the low identifier bits index. All memory traffic goes through one read port. Each request carries an address and a beat count. Responses return 64 bits per beat in ascending address order. Only one walk is in flight at a time. A walk that cannot finish returns a fault response that carries a code.

Top module: `stream_table_walker`

## Requirements
- R1: A request is accepted (`req_ready` high) only while no walk is in progress and no result is pending; after an acceptance `req_ready` stays low until the result has been taken.
- R2: In the flat layout, the entry is read as one 8-beat request at address (`cfg_base` with its low 6 bits forced to zero) + stream ID × 64.
- R3: In the two-level layout, a 1-beat request first reads the descriptor at aligned base + `sid[15:8]` × 8. The entry is then read as an 8-beat request at (descriptor bits [47:6] with 6 zero bits appended) + `sid[7:0]` × 64.
- R4: A level-1 descriptor with bit 0 clear ends the walk with fault code 2, and no entry read is issued.
- R5: A stream ID with `sid >> cfg_log2size` non-zero ends the walk with fault code 1 and no memory request at all.
- R6: Entry layout: beat 0 bit 0 is valid, beat 0 bits [3:1] are the mode, beat 0 bits [47:6] are the context pointer (64-byte aligned), beat 1 bits [15:0] are the VM tag, and beat 2 bits [47:12] are the stage-2 base (4 KB aligned). All other bits and beats are ignored. A clear valid bit gives fault code 3.
- R7: Mode 000 (abort) gives fault code 5. Modes 001, 010 and 011 are invalid and give fault code 4.
- R8: Mode 100 (bypass) and mode 110 (stage 2 only) return a result with `res_fault` low and no context-descriptor read. The total number of memory requests is then one for the flat layout and two for the two-level layout.
- R9: Modes 101 (stage 1) and 111 (both stages) read the context descriptor as an 8-beat request at context pointer + task index × 64. In that descriptor, beat 0 bit 0 is valid and bits [47:4] are the stage-1 table base. A clear valid bit gives fault code 6.
- R10: A memory request is held with a stable address and beat count until `mem_req_ready`. A result is held with stable contents until `res_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 48 | Stream table base address |
| cfg_two_level | input | 1 | 1 selects the split two-level layout |
| cfg_log2size | input | 5 | log2 of the number of stream IDs covered |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_sid | input | 16 | Stream identifier |
| req_ssid | input | 8 | Task (context descriptor) index |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 48 | Read start address |
| mem_req_beats | output | 4 | Number of 64-bit beats requested |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 64 | Read data beat |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken |
| res_fault | output | 1 | Result is a fault |
| res_fault_code | output | 3 | Fault reason (0 none) |
| res_mode | output | 3 | Translation mode from the entry |
| res_vmid | output | 16 | Virtual-machine tag |
| res_s1_ctx | output | 48 | Stage-1 context pointer |
| res_s2_base | output | 48 | Stage-2 table base |
| res_cd_addr | output | 48 | Context descriptor address (stage-1 modes, else 0) |
| res_s1_ttb | output | 48 | Stage-1 table base from the context descriptor |

## Verification
Walks are run with both layouts and with every class of mode value: bypass, stage 2 only, stage 1 through a context descriptor, abort, and an invalid code. This shows that the mode decides both the result and how many reads are issued. Corrupt inputs are run at each level: an identifier beyond the table size, a level-1 descriptor with its valid bit clear, an entry with its valid bit clear, and a descriptor with its valid bit clear. Each must produce its own fault code and stop the walk after the right number of reads. Entries carry nonzero data in bits and beats that must be ignored, so a decoder that reads the wrong bits shows up as wrong field values. A result is also held back without `res_ready` to confirm that it stays stable.

// File: rtl/stw_pkg.sv
// Shared types and constants for the stream table walker.
// Assumes 64-bit read beats and 64-byte entries and context descriptors.
package stw_pkg;

    localparam int ENTRY_SHIFT = 6;   // 64-byte entries and descriptors
    localparam int DESC_SHIFT  = 3;   // 8-byte level-1 descriptors

    // Walk controller states
    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_L1    = 3'd1,
        WS_STE   = 3'd2,
        WS_CD    = 3'd3,
        WS_DONE  = 3'd4,
        WS_FAULT = 3'd5
    } walk_state_e;

    // Fault reasons reported on res_fault_code
    typedef enum logic [2:0] {
        FLT_NONE        = 3'd0,
        FLT_RANGE       = 3'd1,
        FLT_L1_INVALID  = 3'd2,
        FLT_STE_INVALID = 3'd3,
        FLT_BAD_CFG     = 3'd4,
        FLT_ABORT       = 3'd5,
        FLT_CD_INVALID  = 3'd6
    } fault_e;

    // Which record the beat capture is filling
    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_STE  = 2'd1,
        CAP_CD   = 2'd2
    } cap_sel_e;

    // Translation mode codes held in the entry
    localparam logic [2:0] MODE_ABORT  = 3'b000;
    localparam logic [2:0] MODE_BYPASS = 3'b100;
    localparam logic [2:0] MODE_S1     = 3'b101;
    localparam logic [2:0] MODE_S2     = 3'b110;
    localparam logic [2:0] MODE_NESTED = 3'b111;

endpackage

// File: rtl/stw_mem_reader.sv
// Issues one multi-beat read at a time and numbers the returning beats.
// Assumes the responder returns exactly the requested beat count, in order,
// after accepting the request. A new start on the last beat is taken at once.
module stw_mem_reader #(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [BEAT_W-1:0] start_beats,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [BEAT_W-1:0] mem_req_beats,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [DATA_W-1:0] beat_data,
    output logic              last_beat
);

    typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_RSP} rd_state_e;

    rd_state_e         st;
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] beats_q;
    logic [BEAT_W-1:0] cnt_q;

    // Request, beat counting and back-to-back restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RD_IDLE;
            addr_q  <= '0;
            beats_q <= '0;
            cnt_q   <= '0;
        end else begin
            case (st)
                RD_IDLE: begin
                    if (start) begin
                        addr_q  <= start_addr;
                        beats_q <= start_beats;
                        st      <= RD_REQ;
                    end
                end
                RD_REQ: begin
                    if (mem_req_ready) begin
                        cnt_q <= '0;
                        st    <= RD_RSP;
                    end
                end
                RD_RSP: begin
                    if (mem_rsp_valid) begin
                        cnt_q <= cnt_q + BEAT_W'(1);
                        if (cnt_q == beats_q - BEAT_W'(1)) begin
                            if (start) begin
                                addr_q  <= start_addr;
                                beats_q <= start_beats;
                                st      <= RD_REQ;
                            end else begin
                                st <= RD_IDLE;
                            end
                        end
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (st == RD_REQ);
    assign mem_req_addr  = addr_q;
    assign mem_req_beats = beats_q;
    assign beat_valid    = (st == RD_RSP) && mem_rsp_valid;
    assign beat_idx      = cnt_q;
    assign beat_data     = mem_rsp_data;
    assign last_beat     = beat_valid && (cnt_q == beats_q - BEAT_W'(1));

endmodule

// File: rtl/stw_addr_gen.sv
// Computes every table address the walk can need from the current indices.
// Assumes the table base is 64-byte aligned (low bits are dropped here).
module stw_addr_gen
    import stw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int SID_W  = 16,
    parameter int SSID_W = 8,
    parameter int SPLIT  = 8
) (
    input  logic [SID_W-1:0]  sid,
    input  logic [SSID_W-1:0] ssid,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] l2_ptr,
    input  logic [ADDR_W-1:0] s1_ctx,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] ste_lin_addr,
    output logic [ADDR_W-1:0] ste_l2_addr,
    output logic [ADDR_W-1:0] cd_addr
);

    localparam int L2_W = SID_W - SPLIT;

    logic [ADDR_W-1:0] base_al;
    logic [SPLIT-1:0]  l1_idx;
    logic [L2_W-1:0]   l2_idx;

    // Index extraction and base alignment
    assign base_al = {base[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
    assign l1_idx  = sid[SID_W-1 -: SPLIT];
    assign l2_idx  = sid[L2_W-1:0];

    // Scaled index plus base for each table
    assign l1_addr      = base_al + (ADDR_W'(l1_idx) << DESC_SHIFT);
    assign ste_lin_addr = base_al + (ADDR_W'(sid)    << ENTRY_SHIFT);
    assign ste_l2_addr  = l2_ptr  + (ADDR_W'(l2_idx) << ENTRY_SHIFT);
    assign cd_addr      = s1_ctx  + (ADDR_W'(ssid)   << ENTRY_SHIFT);

endmodule

// File: rtl/stw_entry_capture.sv
// Latches the needed fields out of entry and descriptor beats as they pass.
// Assumes beats are numbered from 0 in ascending address order.
module stw_entry_capture
    import stw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int VMID_W = 16,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_sel_e          sel,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [DATA_W-1:0] beat_data,
    output logic              ste_valid,
    output logic [2:0]        ste_mode,
    output logic [ADDR_W-1:0] s1_ctx,
    output logic [VMID_W-1:0] vmid,
    output logic [ADDR_W-1:0] s2_base,
    output logic              cd_valid,
    output logic [ADDR_W-1:0] cd_ttb
);

    logic unused_bits;
    assign unused_bits = ^{beat_data[DATA_W-1:ADDR_W], beat_data[5:4]};

    // Field capture keyed by record type and beat number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ste_valid <= 1'b0;
            ste_mode  <= '0;
            s1_ctx    <= '0;
            vmid      <= '0;
            s2_base   <= '0;
            cd_valid  <= 1'b0;
            cd_ttb    <= '0;
        end else if (beat_valid) begin
            if (sel == CAP_STE) begin
                if (beat_idx == BEAT_W'(0)) begin
                    ste_valid <= beat_data[0];
                    ste_mode  <= beat_data[3:1];
                    s1_ctx    <= {beat_data[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
                end
                if (beat_idx == BEAT_W'(1)) begin
                    vmid <= beat_data[VMID_W-1:0];
                end
                if (beat_idx == BEAT_W'(2)) begin
                    s2_base <= {beat_data[ADDR_W-1:12], 12'b0};
                end
            end else if (sel == CAP_CD) begin
                if (beat_idx == BEAT_W'(0)) begin
                    cd_valid <= beat_data[0];
                    cd_ttb   <= {beat_data[ADDR_W-1:4], 4'b0};
                end
            end
        end
    end

endmodule

// File: rtl/stream_table_walker.sv
// Resolves a stream ID (and task index) into translation configuration by
// walking a flat or two-level stream table, then a context descriptor.
// Assumes one walk in flight; configuration inputs are sampled at acceptance
// and at the first read only, and must be stable while a walk runs.
module stream_table_walker
    import stw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int SID_W  = 16,
    parameter int SSID_W = 8,
    parameter int VMID_W = 16,
    parameter int SPLIT  = 8,
    localparam int LOG_W  = $clog2(SID_W + 1),
    localparam int BEATS  = 64 / (DATA_W / 8),
    localparam int BEAT_W = $clog2(BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_two_level,
    input  logic [LOG_W-1:0]  cfg_log2size,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SID_W-1:0]  req_sid,
    input  logic [SSID_W-1:0] req_ssid,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [BEAT_W-1:0] mem_req_beats,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic [2:0]        res_fault_code,
    output logic [2:0]        res_mode,
    output logic [VMID_W-1:0] res_vmid,
    output logic [ADDR_W-1:0] res_s1_ctx,
    output logic [ADDR_W-1:0] res_s2_base,
    output logic [ADDR_W-1:0] res_cd_addr,
    output logic [ADDR_W-1:0] res_s1_ttb
);

    walk_state_e       state, state_d;
    fault_e            fault_q, fault_d;
    logic [SID_W-1:0]  sid_q;
    logic [SSID_W-1:0] ssid_q;
    logic [ADDR_W-1:0] cd_addr_q;

    logic              rd_start;
    logic [ADDR_W-1:0] rd_addr;
    logic [BEAT_W-1:0] rd_beats;
    logic              beat_valid, last_beat;
    logic [BEAT_W-1:0] beat_idx;
    logic [DATA_W-1:0] beat_data;
    cap_sel_e          cap_sel;

    logic              ste_valid, cd_valid;
    logic [2:0]        ste_mode;
    logic [ADDR_W-1:0] s1_ctx, s2_base, cd_ttb;
    logic [VMID_W-1:0] vmid;

    logic [SID_W-1:0]  sid_mux;
    logic [ADDR_W-1:0] l2_ptr;
    logic [ADDR_W-1:0] l1_addr, ste_lin_addr, ste_l2_addr, cd_addr;
    logic              sid_out_of_range;

    logic unused_bits;
    assign unused_bits = ^{beat_data[DATA_W-1:ADDR_W], beat_data[5:1]};

    // Index sources: live request while idle, latched copy afterwards
    assign sid_mux = (state == WS_IDLE) ? req_sid : sid_q;
    assign l2_ptr  = {beat_data[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};

    // Stream IDs at or above 2^cfg_log2size are outside the table
    assign sid_out_of_range = ((32'(req_sid)) >> cfg_log2size) != 32'd0;

    stw_addr_gen #(
        .ADDR_W(ADDR_W), .SID_W(SID_W), .SSID_W(SSID_W), .SPLIT(SPLIT)
    ) u_addr (
        .sid(sid_mux), .ssid(ssid_q), .base(cfg_base), .l2_ptr(l2_ptr),
        .s1_ctx(s1_ctx), .l1_addr(l1_addr), .ste_lin_addr(ste_lin_addr),
        .ste_l2_addr(ste_l2_addr), .cd_addr(cd_addr)
    );

    stw_mem_reader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)
    ) u_reader (
        .clk(clk), .rst_n(rst_n), .start(rd_start), .start_addr(rd_addr),
        .start_beats(rd_beats), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_beats(mem_req_beats), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .beat_valid(beat_valid),
        .beat_idx(beat_idx), .beat_data(beat_data), .last_beat(last_beat)
    );

    stw_entry_capture #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VMID_W(VMID_W), .BEAT_W(BEAT_W)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .sel(cap_sel), .beat_valid(beat_valid),
        .beat_idx(beat_idx), .beat_data(beat_data), .ste_valid(ste_valid),
        .ste_mode(ste_mode), .s1_ctx(s1_ctx), .vmid(vmid), .s2_base(s2_base),
        .cd_valid(cd_valid), .cd_ttb(cd_ttb)
    );

    // Capture target follows the read currently in progress
    always_comb begin
        case (state)
            WS_STE:  cap_sel = CAP_STE;
            WS_CD:   cap_sel = CAP_CD;
            default: cap_sel = CAP_NONE;
        endcase
    end

    // Walk sequencing: next state, fault reason and read launches
    always_comb begin
        state_d  = state;
        fault_d  = fault_q;
        rd_start = 1'b0;
        rd_addr  = '0;
        rd_beats = '0;
        case (state)
            WS_IDLE: begin
                if (req_valid) begin
                    fault_d = FLT_NONE;
                    if (sid_out_of_range) begin
                        fault_d = FLT_RANGE;
                        state_d = WS_FAULT;
                    end else if (cfg_two_level) begin
                        rd_start = 1'b1;
                        rd_addr  = l1_addr;
                        rd_beats = BEAT_W'(1);
                        state_d  = WS_L1;
                    end else begin
                        rd_start = 1'b1;
                        rd_addr  = ste_lin_addr;
                        rd_beats = BEAT_W'(BEATS);
                        state_d  = WS_STE;
                    end
                end
            end
            WS_L1: begin
                if (last_beat) begin
                    if (!beat_data[0]) begin
                        fault_d = FLT_L1_INVALID;
                        state_d = WS_FAULT;
                    end else begin
                        rd_start = 1'b1;
                        rd_addr  = ste_l2_addr;
                        rd_beats = BEAT_W'(BEATS);
                        state_d  = WS_STE;
                    end
                end
            end
            WS_STE: begin
                if (last_beat) begin
                    if (!ste_valid) begin
                        fault_d = FLT_STE_INVALID;
                        state_d = WS_FAULT;
                    end else begin
                        case (ste_mode)
                            MODE_ABORT: begin
                                fault_d = FLT_ABORT;
                                state_d = WS_FAULT;
                            end
                            MODE_BYPASS, MODE_S2: begin
                                state_d = WS_DONE;
                            end
                            MODE_S1, MODE_NESTED: begin
                                rd_start = 1'b1;
                                rd_addr  = cd_addr;
                                rd_beats = BEAT_W'(BEATS);
                                state_d  = WS_CD;
                            end
                            default: begin
                                fault_d = FLT_BAD_CFG;
                                state_d = WS_FAULT;
                            end
                        endcase
                    end
                end
            end
            WS_CD: begin
                if (last_beat) begin
                    if (cd_valid) begin
                        state_d = WS_DONE;
                    end else begin
                        fault_d = FLT_CD_INVALID;
                        state_d = WS_FAULT;
                    end
                end
            end
            WS_DONE, WS_FAULT: begin
                if (res_ready) state_d = WS_IDLE;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // State, fault reason and request index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WS_IDLE;
            fault_q   <= FLT_NONE;
            sid_q     <= '0;
            ssid_q    <= '0;
            cd_addr_q <= '0;
        end else begin
            state   <= state_d;
            fault_q <= fault_d;
            if (state == WS_IDLE && req_valid) begin
                sid_q     <= req_sid;
                ssid_q    <= req_ssid;
                cd_addr_q <= '0;
            end
            if (state == WS_STE && rd_start) begin
                cd_addr_q <= cd_addr;
            end
        end
    end

    assign req_ready      = (state == WS_IDLE);
    assign res_valid      = (state == WS_DONE) || (state == WS_FAULT);
    assign res_fault      = (state == WS_FAULT);
    assign res_fault_code = fault_q;
    assign res_mode       = ste_mode;
    assign res_vmid       = vmid;
    assign res_s1_ctx     = s1_ctx;
    assign res_s2_base    = s2_base;
    assign res_cd_addr    = cd_addr_q;
    assign res_s1_ttb     = cd_ttb;

endmodule

// File: rtl/stw_walker_chk.sv
// Protocol and result checks for stream_table_walker, attached by bind.
// Assumes it sees the top-level ports only.
module stw_walker_chk #(
    parameter int ADDR_W = 48,
    parameter int BEAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [BEAT_W-1:0] mem_req_beats,
    input logic              res_valid,
    input logic              res_ready,
    input logic              res_fault,
    input logic [2:0]        res_fault_code,
    input logic [2:0]        res_mode
);

    // R1: accepting only while nothing is in flight or pending
    p_accept_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!res_valid && !mem_req_valid));

    // R10: memory request stays put until accepted
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_beats)));

    // R10: result stays put until taken
    p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_fault) && $stable(res_fault_code)));

    // R2: every 8-beat read starts on a 64-byte boundary
    p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_beats == BEAT_W'(8)) |-> (mem_req_addr[5:0] == 6'd0));

    // R3: descriptor reads are single 8-byte aligned beats
    p_desc_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_beats != BEAT_W'(8)) |->
            (mem_req_beats == BEAT_W'(1) && mem_req_addr[2:0] == 3'd0));

    // R8: a successful result always carries a translating or bypass mode
    p_ok_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_mode[2] && res_fault_code == 3'd0));

    // R7: a fault result always carries a reason
    p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_fault_code != 3'd0));

endmodule

bind stream_table_walker stw_walker_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_beats(mem_req_beats),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_fault_code(res_fault_code), .res_mode(res_mode)
);

// File: tb/stream_table_walker_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, memory modelled as a sparse array.
module stream_table_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] cfg_base = '0;
    logic        cfg_two_level = 1'b0;
    logic [4:0]  cfg_log2size = 5'd8;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sid = '0;
    logic [7:0]  req_ssid = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [47:0] mem_req_addr;
    logic [3:0]  mem_req_beats;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic        res_fault;
    logic [2:0]  res_fault_code;
    logic [2:0]  res_mode;
    logic [15:0] res_vmid;
    logic [47:0] res_s1_ctx, res_s2_base, res_cd_addr, res_s1_ttb;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [63:0] mem [logic [47:0]];
    int          n_mreq = 0;
    logic [47:0] mreq_addr [8];
    logic [3:0]  mreq_beats [8];

    stream_table_walker u_dut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [63:0] rd(input logic [47:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'hA5A5_A5A5_A5A5_A5A5;
    endfunction

    // Memory responder: delayed accept, then the requested beats in order
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [47:0] a;
                logic [3:0]  n;
                a = mem_req_addr;
                n = mem_req_beats;
                if (n_mreq < 8) begin
                    mreq_addr[n_mreq]  = a;
                    mreq_beats[n_mreq] = n;
                end
                n_mreq++;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int i = 0; i < int'(n); i++) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(a + 48'(8 * i));
                    @(negedge clk);
                end
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [47:0] a, input logic [63:0] b0,
                       input logic [63:0] b1, input logic [63:0] b2);
        mem[a] = b0;
        mem[a + 48'd8] = b1;
        mem[a + 48'd16] = b2;
    endtask

    // Present one lookup; confirm it is taken and req_ready then drops (R1)
    task automatic issue(input logic [15:0] sid, input logic [7:0] ssid);
        @(negedge clk);
        n_mreq = 0;
        req_sid = sid;
        req_ssid = ssid;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "req_ready after accept", 64'(req_ready), 64'd0);
    endtask

    task automatic wait_res();
        int k;
        k = 0;
        while (!res_valid && k < 400) begin
            @(negedge clk);
            k++;
        end
        check("R10", "result arrives", 64'(res_valid), 64'd1);
    endtask

    task automatic take_res();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check("R1", "ready again after result taken", 64'(req_ready), 64'd1);
    endtask

    task automatic expect_fault(input string tag, input logic [2:0] code, input int nreq);
        wait_res();
        check(tag, "fault flag", 64'(res_fault), 64'd1);
        check(tag, "fault code", 64'(res_fault_code), 64'(code));
        check(tag, "memory requests", 64'(n_mreq), 64'(nreq));
        take_res();
    endtask

    task automatic t_reset();
        check("R1", "reset req_ready", 64'(req_ready), 64'd1);
        check("R1", "reset res_valid", 64'(res_valid), 64'd0);
        check("R10", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    endtask

    // R2, R6, R8: flat table, bypass entry, unaligned base bits dropped
    task automatic t_linear_bypass();
        cfg_two_level = 1'b0;
        cfg_log2size = 5'd8;
        cfg_base = 48'h1_0015;
        put(48'h1_0140, 64'hFFFF_0000_0000_0009, 64'hFFFF_0000_0000_1234, 64'h0000_0000_0000_0FFF);
        issue(16'd5, 8'd0);
        wait_res();
        check("R2", "entry read addr", 64'(mreq_addr[0]), 64'h1_0140);
        check("R2", "entry read beats", 64'(mreq_beats[0]), 64'd8);
        check("R8", "bypass not a fault", 64'(res_fault), 64'd0);
        check("R8", "bypass requests", 64'(n_mreq), 64'd1);
        check("R6", "mode", 64'(res_mode), 64'd4);
        check("R6", "vmid", 64'(res_vmid), 64'h1234);
        check("R6", "s2 base low bits ignored", 64'(res_s2_base), 64'd0);
        check("R8", "no cd addr", 64'(res_cd_addr), 64'd0);
        take_res();
    endtask

    // R8, R6: stage-2 only
    task automatic t_stage2_only();
        put(48'h1_01C0, 64'h0000_0000_0000_000D, 64'h0000_0000_0000_0042, 64'h0000_0000_7777_7123);
        issue(16'd7, 8'd3);
        wait_res();
        check("R8", "s2-only not a fault", 64'(res_fault), 64'd0);
        check("R8", "s2-only requests", 64'(n_mreq), 64'd1);
        check("R6", "s2-only mode", 64'(res_mode), 64'd6);
        check("R6", "s2-only base", 64'(res_s2_base), 64'h7777_7000);
        check("R6", "s2-only vmid", 64'(res_vmid), 64'h42);
        take_res();
    endtask

    task automatic t_range();
        issue(16'h0100, 8'd0);
        expect_fault("R5", 3'd1, 0);
    endtask

    task automatic t_ste_invalid();
        put(48'h1_0200, 64'h0000_0000_0000_0008, 64'h0, 64'h0);
        issue(16'd8, 8'd0);
        expect_fault("R6", 3'd3, 1);
    endtask

    task automatic t_modes_bad();
        put(48'h1_0240, 64'h0000_0000_0000_0001, 64'h0, 64'h0);
        issue(16'd9, 8'd0);
        expect_fault("R7", 3'd5, 1);
        put(48'h1_0280, 64'h0000_0000_0000_0007, 64'h0, 64'h0);
        issue(16'd10, 8'd0);
        expect_fault("R7", 3'd4, 1);
    endtask

    task automatic t_cd_invalid();
        put(48'h1_02C0, 64'h0000_0000_0009_000B, 64'h0, 64'h0);
        mem[48'h9_0040] = 64'h0000_0000_0000_0500;
        issue(16'd11, 8'd1);
        wait_res();
        check("R9", "cd read addr", 64'(mreq_addr[1]), 64'h9_0040);
        check("R9", "cd fault code", 64'(res_fault_code), 64'd6);
        check("R9", "cd fault requests", 64'(n_mreq), 64'd2);
        take_res();
    endtask

    // R3, R9, R10: two-level walk ending in a nested-mode descriptor read
    task automatic t_two_level_nested();
        cfg_two_level = 1'b1;
        cfg_log2size = 5'd16;
        cfg_base = 48'h2_0000;
        mem[48'h2_0018] = 64'h0000_0000_0004_0001;
        put(48'h4_0480, 64'h0000_0000_0008_000F, 64'hFFFF_0000_0000_0055, 64'h0000_0001_2345_6000);
        mem[48'h8_0080] = 64'h0000_0000_00AB_CDE1;
        issue(16'h0312, 8'd2);
        wait_res();
        check("R3", "l1 read addr", 64'(mreq_addr[0]), 64'h2_0018);
        check("R3", "l1 read beats", 64'(mreq_beats[0]), 64'd1);
        check("R3", "l2 entry addr", 64'(mreq_addr[1]), 64'h4_0480);
        check("R9", "cd addr on port", 64'(mreq_addr[2]), 64'h8_0080);
        check("R9", "request count", 64'(n_mreq), 64'd3);
        check("R9", "not a fault", 64'(res_fault), 64'd0);
        check("R6", "nested mode", 64'(res_mode), 64'd7);
        check("R6", "s1 ctx", 64'(res_s1_ctx), 64'h8_0000);
        check("R6", "vmid upper bits ignored", 64'(res_vmid), 64'h55);
        check("R6", "s2 base", 64'(res_s2_base), 64'h1_2345_6000);
        check("R9", "cd addr result", 64'(res_cd_addr), 64'h8_0080);
        check("R9", "s1 ttb", 64'(res_s1_ttb), 64'hAB_CDE0);
        repeat (3) @(negedge clk);
        check("R10", "result held", 64'(res_valid), 64'd1);
        check("R10", "held ttb stable", 64'(res_s1_ttb), 64'hAB_CDE0);
        take_res();
    endtask

    task automatic t_l1_invalid();
        mem[48'h2_0020] = 64'h0000_0000_0004_0000;
        issue(16'h0400, 8'd0);
        expect_fault("R4", 3'd2, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear_bypass();
        t_stage2_only();
        t_range();
        t_ste_invalid();
        t_modes_bad();
        t_cd_invalid();
        t_two_level_nested();
        t_l1_invalid();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule